// File: doc/BRIEF.md
# Multiprocessor Startup Sequencer

This block is a hardware state machine that sits beside the bootstrap processor and wakes the secondary processors of a shared-memory system. After a single start pulse it first seeds the shared check-in counter with 1, which accounts for the bootstrap processor itself. It then broadcasts three interrupt-command messages to every processor other than itself: first an INIT message, then two start-up messages. Each start-up message carries an 8-bit vector that names the entry page of the woken processors, so vector V means entry address V shifted left by 12 (0x11 gives 0x00011000).

After each command write the sequencer polls the command unit's delivery-status bit and waits for it to return to idle. It then arms an external microsecond delay timer and waits for the timer to expire. The wait after INIT is 10 000 µs, and the wait after each start-up message is 200 µs. When the last wait ends, the sequencer registers the value of the check-in counter as the processor total and pulses done.

Delivery status may stay pending for too long. If it does, the sequencer abandons the run and raises an error flag. The flag holds until the next accepted start.

Top module: `mp_wake_seq`

## Requirements
- R1: Out of reset, busy_o, done_o, err_o, cpu_total_o, icr_lo_wr_o, tmr_load_o and cpu_cnt_wr_o are all 0.
- R2: A start_i pulse while idle raises busy_o on the next cycle. The first action of the run is a single write of the value 1 to the check-in counter, made before any command write.
- R3: A successful run makes exactly three command writes, in this order: INIT word 0x000C4500, then the start-up word 0x000C4600 OR vector, written twice. The field layout is: vector in bits 7:0; delivery mode in bits 10:8 (101 = INIT, 110 = start-up); level-assert in bit 14 (set to 1); destination shorthand in bits 19:18 (11 = all except self).
- R4: After a command write, the sequencer does not load the timer while icr_pending_i reads 1. It loads the timer only after icr_pending_i has read 0.
- R5: The timer loads carry 10000 after INIT and 200 after each start-up message. No command write occurs before the running wait has expired.
- R6: When the third wait expires, done_o is high for exactly one cycle, in the cycle after the edge that samples the expiry. In that cycle busy_o is 0 and cpu_total_o equals the value of cpu_cnt_i seen at that edge.
- R7: A start_i pulse while busy_o is high is ignored. The run still makes one counter seed, three command writes, three timer loads and one done pulse.
- R8: With a timeout value T on poll_limit_i, up to T consecutive pending reads are tolerated. The (T+1)-th consecutive pending read aborts the run: err_o goes to 1, busy_o goes to 0, no timer load follows and done_o stays 0. err_o returns to 0 when the next start is accepted.
- R9: The vector is captured when start is accepted. Later changes on sipi_vec_i have no effect on the start-up words of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| sipi_vec_i | input | VEC_W | Start-up vector (entry page number) |
| poll_limit_i | input | TO_W | Number of pending status reads tolerated |
| icr_lo_wr_o | output | 1 | Write strobe for the command unit's low word |
| icr_lo_data_o | output | 32 | Command low-word data |
| icr_pending_i | input | 1 | Delivery-status bit (bit 12 of the low word), 1 = pending |
| tmr_load_o | output | 1 | Load strobe for the delay timer |
| tmr_us_o | output | TUS_W | Delay in microseconds |
| tmr_expired_i | input | 1 | Timer expiry pulse |
| cpu_cnt_wr_o | output | 1 | Write strobe for the shared check-in counter |
| cpu_cnt_wdata_o | output | CNT_W | Seed value for the counter (1) |
| cpu_cnt_i | input | CNT_W | Current check-in counter value |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cpu_total_o | output | CNT_W | Registered processor total |
| err_o | output | 1 | Run aborted on delivery timeout |

## Verification
The bench attaches models of the command unit, the timer and the counter, and records every strobe at the clock edge that consumes it. Cycle positions follow from the register path. The counter seed appears one cycle after the start edge and the first command write one cycle after that. The status reads begin in the cycle after each write, and the timer load comes one cycle after the first idle read. The done pulse is checked in the exact cycle after the edge where the final expiry was seen, and is checked to be gone one cycle later. The checks sweep the pending length from 0 to T+1 for several timeout values T, so both the last tolerated read and the first fatal read are compared against the arithmetic expectation.

// File: rtl/mws_pkg.sv
package mws_pkg;
   localparam int unsigned ICR_W   = 32;
   localparam int unsigned VEC_LSB = 0;
   localparam int unsigned DM_LSB  = 8;
   localparam int unsigned LVL_BIT = 14;
   localparam int unsigned SH_LSB  = 18;
   localparam logic [2:0] DM_INIT  = 3'b101;
   localparam logic [2:0] DM_START = 3'b110;
   localparam logic [1:0] SH_OTHERS = 2'b11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEED,
      ST_SEND,
      ST_POLL,
      ST_ARM,
      ST_WAIT
   } seq_st_t;
endpackage

// File: rtl/mws_cmd_fmt.sv
module mws_cmd_fmt
   import mws_pkg::*;
#(
   parameter int unsigned VEC_W = 8
) (
   input  logic             is_init_i,
   input  logic [VEC_W-1:0] vec_i,
   output logic [ICR_W-1:0] word_o
);
   logic [7:0] vec8;

   generate
      if (VEC_W > 8 || VEC_W == 0) begin : g_bad_vec
         $error("mws_cmd_fmt: VEC_W must be 1..8");
      end else if (VEC_W == 8) begin : g_full
         assign vec8 = vec_i;
      end else begin : g_pad
         assign vec8 = {{(8-VEC_W){1'b0}}, vec_i};
      end
   endgenerate

   always_comb begin
      word_o                  = '0;
      word_o[VEC_LSB +: 8]    = is_init_i ? 8'h00 : vec8;
      word_o[DM_LSB +: 3]     = is_init_i ? DM_INIT : DM_START;
      word_o[LVL_BIT]         = 1'b1;
      word_o[SH_LSB +: 2]     = SH_OTHERS;
   end

   always_comb begin
      a_r3_mode_field : assert (word_o[DM_LSB +: 3] == DM_INIT || word_o[DM_LSB +: 3] == DM_START);
   end
endmodule

// File: rtl/mws_poll_guard.sv
module mws_poll_guard #(
   parameter int unsigned TO_W       = 8,
   parameter bit          TIMEOUT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            poll_i,
   input  logic            pending_i,
   input  logic [TO_W-1:0] limit_i,
   output logic            abort_o
);
   generate
      if (TO_W == 0) begin : g_bad_w
         $error("mws_poll_guard: TO_W must be nonzero");
      end
      if (TIMEOUT_EN) begin : g_timed
         logic [TO_W-1:0] seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_q <= '0;
            end else if (clear_i) begin
               seen_q <= '0;
            end else if (poll_i && pending_i && seen_q != limit_i) begin
               seen_q <= seen_q + TO_W'(1);
            end
         end
         assign abort_o = poll_i && pending_i && (seen_q == limit_i);

         a_r8_first_read_tolerated : assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clear_i) && poll_i && pending_i && limit_i != '0) |-> !abort_o);
      end else begin : g_untimed
         assign abort_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/mws_seq_fsm.sv
module mws_seq_fsm
   import mws_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TUS_W     = 16,
   parameter int unsigned INIT_US   = 10000,
   parameter int unsigned SU_US     = 200,
   parameter int unsigned SU_REPEAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             pending_i,
   input  logic             abort_i,
   input  logic             expired_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             cap_o,
   output logic             seed_wr_o,
   output logic             send_o,
   output logic             is_init_o,
   output logic             poll_o,
   output logic             guard_clr_o,
   output logic             tmr_load_o,
   output logic [TUS_W-1:0] tmr_us_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [CNT_W-1:0] total_o,
   output logic             err_o
);
   localparam int unsigned STEP_W = $clog2(SU_REPEAT + 1);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SU_REPEAT);

   seq_st_t           st_q;
   logic [STEP_W-1:0] step_q;
   logic              done_q;
   logic              err_q;
   logic [CNT_W-1:0]  tot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         step_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         tot_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q   <= ST_SEED;
               step_q <= '0;
               err_q  <= 1'b0;
            end
            ST_SEED: st_q <= ST_SEND;
            ST_SEND: st_q <= ST_POLL;
            ST_POLL: begin
               if (!pending_i) begin
                  st_q <= ST_ARM;
               end else if (abort_i) begin
                  st_q  <= ST_IDLE;
                  err_q <= 1'b1;
               end
            end
            ST_ARM: st_q <= ST_WAIT;
            ST_WAIT: if (expired_i) begin
               if (step_q == LAST_STEP) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  tot_q  <= cnt_i;
               end else begin
                  step_q <= step_q + STEP_W'(1);
                  st_q   <= ST_SEND;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cap_o       = (st_q == ST_IDLE) && start_i;
   assign seed_wr_o   = (st_q == ST_SEED);
   assign send_o      = (st_q == ST_SEND);
   assign guard_clr_o = (st_q == ST_SEND);
   assign poll_o      = (st_q == ST_POLL);
   assign tmr_load_o  = (st_q == ST_ARM);
   assign is_init_o   = (step_q == '0);
   assign tmr_us_o    = is_init_o ? TUS_W'(INIT_US) : TUS_W'(SU_US);
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = done_q;
   assign total_o     = tot_q;
   assign err_o       = err_q;

   a_r6_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r6_done_not_busy : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   a_r7_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> !seed_wr_o);
   a_r4_hold_on_pending : assert property (@(posedge clk) disable iff (!rst_n)
      (poll_o && pending_i) |=> !tmr_load_o);
   a_r5_no_send_in_wait : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !poll_o && !send_o && !seed_wr_o && !tmr_load_o && !expired_i) |=> !send_o);
   a_r8_err_no_done : assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !done_o);
endmodule

// File: rtl/mp_wake_seq.sv
module mp_wake_seq
   import mws_pkg::*;
#(
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned TUS_W      = 16,
   parameter int unsigned TO_W       = 8,
   parameter int unsigned INIT_US    = 10000,
   parameter int unsigned SU_US      = 200,
   parameter int unsigned SU_REPEAT  = 2,
   parameter bit          TIMEOUT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VEC_W-1:0] sipi_vec_i,
   input  logic [TO_W-1:0]  poll_limit_i,
   output logic             icr_lo_wr_o,
   output logic [31:0]      icr_lo_data_o,
   input  logic             icr_pending_i,
   output logic             tmr_load_o,
   output logic [TUS_W-1:0] tmr_us_o,
   input  logic             tmr_expired_i,
   output logic             cpu_cnt_wr_o,
   output logic [CNT_W-1:0] cpu_cnt_wdata_o,
   input  logic [CNT_W-1:0] cpu_cnt_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [CNT_W-1:0] cpu_total_o,
   output logic             err_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("mp_wake_seq: CNT_W must be at least 2");
      end
      if (INIT_US >= (64'd1 << TUS_W) || SU_US >= (64'd1 << TUS_W)) begin : g_bad_tus
         $error("mp_wake_seq: delay does not fit TUS_W");
      end
      if (SU_REPEAT == 0) begin : g_bad_rep
         $error("mp_wake_seq: SU_REPEAT must be nonzero");
      end
   endgenerate

   logic             cap;
   logic             is_init;
   logic             poll;
   logic             guard_clr;
   logic             abort;
   logic [VEC_W-1:0] vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
      end else if (cap) begin
         vec_q <= sipi_vec_i;
      end
   end

   mws_seq_fsm #(
      .CNT_W     (CNT_W),
      .TUS_W     (TUS_W),
      .INIT_US   (INIT_US),
      .SU_US     (SU_US),
      .SU_REPEAT (SU_REPEAT)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .pending_i   (icr_pending_i),
      .abort_i     (abort),
      .expired_i   (tmr_expired_i),
      .cnt_i       (cpu_cnt_i),
      .cap_o       (cap),
      .seed_wr_o   (cpu_cnt_wr_o),
      .send_o      (icr_lo_wr_o),
      .is_init_o   (is_init),
      .poll_o      (poll),
      .guard_clr_o (guard_clr),
      .tmr_load_o  (tmr_load_o),
      .tmr_us_o    (tmr_us_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .total_o     (cpu_total_o),
      .err_o       (err_o)
   );

   mws_poll_guard #(
      .TO_W       (TO_W),
      .TIMEOUT_EN (TIMEOUT_EN)
   ) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (guard_clr),
      .poll_i    (poll),
      .pending_i (icr_pending_i),
      .limit_i   (poll_limit_i),
      .abort_o   (abort)
   );

   mws_cmd_fmt #(
      .VEC_W (VEC_W)
   ) u_fmt (
      .is_init_i (is_init),
      .vec_i     (vec_q),
      .word_o    (icr_lo_data_o)
   );

   assign cpu_cnt_wdata_o = CNT_W'(1);

   a_r2_seed_before_send : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (cpu_cnt_wr_o && !icr_lo_wr_o));
   a_r9_vec_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !cap) |=> $stable(vec_q));
endmodule

// File: tb/sim_mp_wake_seq.sv
module sim_mp_wake_seq;
   localparam logic [31:0] W_INIT = 32'h000C4500;
   localparam logic [31:0] W_SU   = 32'h000C4600;

   logic        clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n   = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  vec_i   = 8'h00;
   logic [7:0]  lim_i   = 8'h00;
   logic        icr_wr;
   logic [31:0] icr_data;
   logic        icr_pend;
   logic        tmr_load;
   logic [15:0] tmr_us;
   logic        tmr_exp;
   logic        cnt_wr;
   logic [7:0]  cnt_wdata;
   logic [7:0]  cnt_rd;
   logic        busy_o, done_o, err_o;
   logic [7:0]  total_o;

   int checks = 0;
   int fails  = 0;
   int pend_len = 0;
   int aps = 0;

   int pend_left = 0;
   int tleft = 0;
   logic [7:0] cnt_mem;
   int cyc = 0;
   int last_exp = -10;
   int n_icr = 0, n_load = 0, n_seed = 0, n_done = 0, viol = 0;
   logic [31:0] icr_log [128];
   int load_log [128];

   assign icr_pend = (pend_left != 0);
   assign tmr_exp  = (tleft == 1);
   assign cnt_rd   = cnt_mem;

   mp_wake_seq u0 (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .sipi_vec_i (vec_i),
      .poll_limit_i (lim_i), .icr_lo_wr_o (icr_wr), .icr_lo_data_o (icr_data),
      .icr_pending_i (icr_pend), .tmr_load_o (tmr_load), .tmr_us_o (tmr_us),
      .tmr_expired_i (tmr_exp), .cpu_cnt_wr_o (cnt_wr), .cpu_cnt_wdata_o (cnt_wdata),
      .cpu_cnt_i (cnt_rd), .busy_o (busy_o), .done_o (done_o),
      .cpu_total_o (total_o), .err_o (err_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         pend_left <= 0;
         tleft     <= 0;
         cnt_mem   <= 8'd77;
      end else begin
         if (icr_wr) begin
            pend_left <= pend_len;
            icr_log[n_icr % 128] <= icr_data;
            n_icr <= n_icr + 1;
            if (tleft > 1) viol <= viol + 1;
            if (icr_data[10:8] == 3'b110) cnt_mem <= cnt_mem + 8'(aps);
         end else if (pend_left > 0) begin
            pend_left <= pend_left - 1;
         end
         if (cnt_wr) begin
            cnt_mem <= cnt_wdata;
            n_seed  <= n_seed + 1;
         end
         if (tmr_load) begin
            tleft <= int'(tmr_us) / 100;
            load_log[n_load % 128] <= int'(tmr_us);
            n_load <= n_load + 1;
            if (icr_pend) viol <= viol + 1;
         end else if (tleft > 0) begin
            tleft <= tleft - 1;
         end
         if (tmr_exp) last_exp <= cyc;
         if (done_o) n_done <= n_done + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_case(input logic [7:0] v, input int p, input int t, input int a,
                           input bit mid_start, input bit vec_flip);
      int i0 = n_icr;
      int l0 = n_load;
      int s0 = n_seed;
      int d0 = n_done;
      bit ab = (p > t);
      pend_len = p;
      aps      = a;
      lim_i    = 8'(t);
      vec_i    = v;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(busy_o == 1'b1, "R2 busy after start", longint'(busy_o), 1);
      chk(err_o == 1'b0, "R8 err cleared on start", longint'(err_o), 0);
      if (vec_flip) vec_i = ~v;
      if (mid_start) begin
         repeat (20) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      chk((n_seed - s0) == 1, "R2/R7 one seed write", longint'(n_seed - s0), 1);
      chk(viol == 0, "R4/R5 ordering violations", longint'(viol), 0);
      if (ab) begin
         chk(err_o == 1'b1, "R8 abort sets err", longint'(err_o), 1);
         chk(done_o == 1'b0, "R8 no done on abort", longint'(done_o), 0);
         chk((n_icr - i0) == 1, "R8 single write before abort", longint'(n_icr - i0), 1);
         chk((n_load - l0) == 0, "R8 no timer load on abort", longint'(n_load - l0), 0);
         chk(cnt_mem == 8'd1, "R2 counter seeded to 1", longint'(cnt_mem), 1);
      end else begin
         chk(done_o == 1'b1, "R6 done pulse", longint'(done_o), 1);
         chk(cyc == last_exp + 1, "R6 done timing", longint'(cyc), longint'(last_exp + 1));
         chk(total_o == 8'(1 + 2 * a), "R6 total", longint'(total_o), longint'(1 + 2 * a));
         chk(err_o == 1'b0, "R8 err low on success", longint'(err_o), 0);
         chk((n_icr - i0) == 3, "R3/R7 three writes", longint'(n_icr - i0), 3);
         chk((n_load - l0) == 3, "R5/R7 three loads", longint'(n_load - l0), 3);
         chk(icr_log[i0 % 128] == W_INIT, "R3 INIT word", longint'(icr_log[i0 % 128]), longint'(W_INIT));
         for (int k = 1; k < 3; k++) begin
            chk(icr_log[(i0 + k) % 128] == (W_SU | {24'h0, v}), "R3/R9 start-up word",
                longint'(icr_log[(i0 + k) % 128]), longint'(W_SU | {24'h0, v}));
         end
         chk(load_log[l0 % 128] == 10000, "R5 INIT wait", longint'(load_log[l0 % 128]), 10000);
         chk(load_log[(l0 + 1) % 128] == 200, "R5 first start-up wait", longint'(load_log[(l0 + 1) % 128]), 200);
         chk(load_log[(l0 + 2) % 128] == 200, "R5 second start-up wait", longint'(load_log[(l0 + 2) % 128]), 200);
         @(negedge clk);
         chk(done_o == 1'b0, "R6 done one cycle", longint'(done_o), 0);
         chk((n_done - d0) == 1, "R6/R7 one done", longint'(n_done - d0), 1);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0, "R1 reset flags",
          longint'({busy_o, done_o, err_o}), 0);
      chk(total_o == 8'h00, "R1 reset total", longint'(total_o), 0);
      chk(icr_wr == 1'b0 && tmr_load == 1'b0 && cnt_wr == 1'b0, "R1 reset strobes",
          longint'({icr_wr, tmr_load, cnt_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && total_o == 8'h00, "R1 idle after release",
          longint'({busy_o, total_o}), 0);
      for (int ti = 0; ti < 3; ti++) begin
         int t = (ti == 0) ? 0 : ti + 1;
         for (int p = 0; p <= t + 1; p++) begin
            run_case(8'h11 + 8'(p * 16 + ti), p, t, p + 1, 1'b0, 1'b0);
         end
      end
      run_case(8'h11, 1, 2, 3, 1'b1, 1'b0);
      run_case(8'h5A, 2, 3, 2, 1'b0, 1'b1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule